// File: doc/BRIEF.md
# Working Register File with Data-Space Aliasing

This block holds the thirty-two 8-bit working registers of a small 8-bit RISC core. The ALU side gets two read ports that answer within the cycle and one write port that commits at the clock edge. Together these let a full register-to-register operation finish in a single cycle. The top six registers pair up into three 16-bit pointers. A step port can advance one pointer by one, forwards or backwards, in a single cycle.

The same registers also sit at the bottom of an 8-bit data address space, so a load/store unit can reach them. The block decodes every data address into one of four regions:
- the register file;
- a 64-entry I/O window, forwarded to an external I/O bus with a rebased address;
- a 128-byte internal SRAM that the block owns;
- an unmapped tail that reads as zero.

The interfaces are plain control pins, and every port is available in every cycle. No port has a valid/ready handshake, because no port ever stalls. A caller may present an ALU write, a data-space access and a pointer step in the same cycle. Fixed priorities resolve any overlap between them.

Top module: `gpr_file`

## Requirements
- R1: The read ports (`rd_a_data`, `rd_b_data`) show the selected register combinationally. An ALU write (`alu_we`) stores `alu_wdata` at the next rising edge.
- R2: A read of a register that is being written in the same cycle returns the value it held before that edge.
- R3: Data addresses 0x00 to 0x1F alias registers 0 to 31. A data-space write there changes the register, and `ds_rdata` shows the current register value.
- R4: Data addresses 0x20 to 0x5F drive `io_addr` with (address − 0x20), raise `io_we`/`io_re` with `ds_we`/`ds_re`, pass `ds_wdata` out on `io_wdata`, and return `io_rdata` on `ds_rdata`. `io_we` and `io_re` stay low for every other address.
- R5: Data addresses 0x60 to 0xDF reach internal SRAM at index (address − 0x60). Writes commit at the edge, and reads are combinational.
- R6: Data addresses 0xE0 to 0xFF read as zero. Writes there change no register and no SRAM byte.
- R7: When an ALU write and a data-space write hit the same register in one cycle, the ALU value is stored.
- R8: `x_ptr` = {r27,r26}, `y_ptr` = {r29,r28} and `z_ptr` = {r31,r30}, with the lower-numbered register holding the low byte. Each output follows its registers continuously.
- R9: When `ptr_en` is high, `ptr_sel` chooses X (0), Y (1) or Z (2), and the value 3 changes nothing. With `ptr_dec`=0 (post-increment), `ptr_addr` equals the old pointer value and the pointer becomes old+1. With `ptr_dec`=1 (pre-decrement), `ptr_addr` and the new pointer value are both old−1. Arithmetic wraps modulo 2^16.
- R10: An ALU write to one byte of a stepping pointer overrides that byte only. A pointer step overrides a data-space write to either byte of the same pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset; register contents are left undefined |
| rd_a_sel | input | 5 | Read port A register index |
| rd_a_data | output | 8 | Read port A data |
| rd_b_sel | input | 5 | Read port B register index |
| rd_b_data | output | 8 | Read port B data |
| alu_we | input | 1 | ALU write enable |
| alu_wsel | input | 5 | ALU write register index |
| alu_wdata | input | 8 | ALU write data |
| ds_addr | input | 8 | Data-space address |
| ds_we | input | 1 | Data-space write strobe |
| ds_re | input | 1 | Data-space read strobe (forwarded to the I/O window) |
| ds_wdata | input | 8 | Data-space write data |
| ds_rdata | output | 8 | Data-space read data |
| io_addr | output | 6 | I/O window offset |
| io_we | output | 1 | I/O write strobe |
| io_re | output | 1 | I/O read strobe |
| io_wdata | output | 8 | I/O write data |
| io_rdata | input | 8 | I/O read data |
| ptr_en | input | 1 | Pointer step enable |
| ptr_sel | input | 2 | Pointer choice: 0 X, 1 Y, 2 Z, 3 none |
| ptr_dec | input | 1 | 0 post-increment, 1 pre-decrement |
| ptr_addr | output | 16 | Effective address of the pointer step |
| x_ptr | output | 16 | Pointer X |
| y_ptr | output | 16 | Pointer Y |
| z_ptr | output | 16 | Pointer Z |

## Verification
The hardest cases to produce are the three-way collisions on a pointer pair. In these, a step, an ALU byte write and a data-space write all land on the same registers in one edge. The stimulus first loads known bytes into the pair through the ALU port. It then fires the step together with a conflicting write, so each priority shows up as a distinct 16-bit value. Pointer wraparound is reached by seeding X with 0xFFFF and stepping it both ways. The unmapped tail is probed at 0xE5, whose low bits alias both SRAM byte 0x65 and register 5, so a write that wrongly leaks through would show on a port.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam int GPR_DW         = 8;
  localparam int GPR_NREG       = 32;
  localparam int GPR_AW         = 8;
  localparam int GPR_IO_BASE    = 32;
  localparam int GPR_IO_DEPTH   = 64;
  localparam int GPR_SRAM_BASE  = 96;
  localparam int GPR_SRAM_DEPTH = 128;

  typedef enum logic [1:0] {
    RG_REG  = 2'd0,
    RG_IO   = 2'd1,
    RG_SRAM = 2'd2,
    RG_NONE = 2'd3
  } region_e;

  typedef enum logic [1:0] {
    PS_X    = 2'd0,
    PS_Y    = 2'd1,
    PS_Z    = 2'd2,
    PS_NONE = 2'd3
  } ptr_sel_e;
endpackage

// File: rtl/gpr_addr_decode.sv
module gpr_addr_decode
  import gpr_pkg::*;
#(
  parameter int AW         = GPR_AW,
  parameter int NREG       = GPR_NREG,
  parameter int IO_BASE    = GPR_IO_BASE,
  parameter int IO_DEPTH   = GPR_IO_DEPTH,
  parameter int SRAM_BASE  = GPR_SRAM_BASE,
  parameter int SRAM_DEPTH = GPR_SRAM_DEPTH
) (
  input  logic [AW-1:0]                 addr,
  output region_e                       region,
  output logic [$clog2(NREG)-1:0]       reg_idx,
  output logic [$clog2(IO_DEPTH)-1:0]   io_off,
  output logic [$clog2(SRAM_DEPTH)-1:0] sram_off
);
  localparam int RW       = $clog2(NREG);
  localparam int IOW      = $clog2(IO_DEPTH);
  localparam int SW       = $clog2(SRAM_DEPTH);
  localparam int IO_END   = IO_BASE + IO_DEPTH;
  localparam int SRAM_END = SRAM_BASE + SRAM_DEPTH;

  logic [AW-1:0] io_rel, sram_rel;

  assign io_rel   = addr - AW'(IO_BASE);
  assign sram_rel = addr - AW'(SRAM_BASE);
  assign reg_idx  = addr[RW-1:0];
  assign io_off   = io_rel[IOW-1:0];
  assign sram_off = sram_rel[SW-1:0];

  always_comb begin
    if (int'(addr) < NREG)          region = RG_REG;
    else if (int'(addr) < IO_END)   region = RG_IO;
    else if (int'(addr) < SRAM_END) region = RG_SRAM;
    else                            region = RG_NONE;
  end
endmodule

// File: rtl/gpr_ptr_step.sv
module gpr_ptr_step #(
  parameter int PW = 16
) (
  input  logic [PW-1:0] cur,
  input  logic          dec,
  output logic [PW-1:0] nxt,
  output logic [PW-1:0] eaddr
);
  logic [PW-1:0] minus_one, plus_one;

  assign minus_one = cur - PW'(1);
  assign plus_one  = cur + PW'(1);
  assign nxt       = dec ? minus_one : plus_one;
  assign eaddr     = dec ? minus_one : cur;
endmodule

// File: rtl/gpr_array.sv
module gpr_array #(
  parameter int DW   = 8,
  parameter int NREG = 32,
  parameter int NPTR = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [$clog2(NREG)-1:0]   rd_a_sel,
  output logic [DW-1:0]             rd_a_data,
  input  logic [$clog2(NREG)-1:0]   rd_b_sel,
  output logic [DW-1:0]             rd_b_data,
  input  logic [$clog2(NREG)-1:0]   rd_c_sel,
  output logic [DW-1:0]             rd_c_data,
  input  logic                      alu_we,
  input  logic [$clog2(NREG)-1:0]   alu_sel,
  input  logic [DW-1:0]             alu_data,
  input  logic                      ptr_we,
  input  logic [$clog2(NREG)-1:0]   ptr_lo_idx,
  input  logic [2*DW-1:0]           ptr_data,
  input  logic                      ds_we,
  input  logic [$clog2(NREG)-1:0]   ds_sel,
  input  logic [DW-1:0]             ds_data,
  output logic [2*DW-1:0]           ptr_val [NPTR]
);
  localparam int RW       = $clog2(NREG);
  localparam int PTR_BASE = NREG - 2 * NPTR;

  logic [DW-1:0] regs [NREG];
  logic [RW-1:0] ptr_hi_idx;

  assign ptr_hi_idx = ptr_lo_idx + RW'(1);
  assign rd_a_data  = regs[rd_a_sel];
  assign rd_b_data  = regs[rd_b_sel];
  assign rd_c_data  = regs[rd_c_sel];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (alu_we && alu_sel == RW'(g))
        regs[g] <= alu_data;
      else if (ptr_we && ptr_lo_idx == RW'(g))
        regs[g] <= ptr_data[DW-1:0];
      else if (ptr_we && ptr_hi_idx == RW'(g))
        regs[g] <= ptr_data[2*DW-1:DW];
      else if (ds_we && ds_sel == RW'(g))
        regs[g] <= ds_data;
    end
  end

  for (genvar p = 0; p < NPTR; p++) begin : g_ptr
    assign ptr_val[p] = {regs[PTR_BASE + 2*p + 1], regs[PTR_BASE + 2*p]};
  end

  // R1: an ALU write is stored at the edge
  p_alu_commit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    alu_we |=> regs[$past(alu_sel)] == $past(alu_data));

  // R7: on a same-register collision the ALU value is the one kept
  p_alu_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (alu_we && ds_we && alu_sel == ds_sel) |=> regs[$past(ds_sel)] == $past(alu_data));

  // R3: an uncontested data-space write lands in its register
  p_ds_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_we && !(alu_we && alu_sel == ds_sel) &&
     !(ptr_we && (ds_sel == ptr_lo_idx || ds_sel == ptr_hi_idx)))
    |=> regs[$past(ds_sel)] == $past(ds_data));
endmodule

// File: rtl/gpr_file.sv
module gpr_file
  import gpr_pkg::*;
#(
  parameter int DW         = GPR_DW,
  parameter int NREG       = GPR_NREG,
  parameter int AW         = GPR_AW,
  parameter int IO_BASE    = GPR_IO_BASE,
  parameter int IO_DEPTH   = GPR_IO_DEPTH,
  parameter int SRAM_BASE  = GPR_SRAM_BASE,
  parameter int SRAM_DEPTH = GPR_SRAM_DEPTH
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [$clog2(NREG)-1:0]     rd_a_sel,
  output logic [DW-1:0]               rd_a_data,
  input  logic [$clog2(NREG)-1:0]     rd_b_sel,
  output logic [DW-1:0]               rd_b_data,
  input  logic                        alu_we,
  input  logic [$clog2(NREG)-1:0]     alu_wsel,
  input  logic [DW-1:0]               alu_wdata,
  input  logic [AW-1:0]               ds_addr,
  input  logic                        ds_we,
  input  logic                        ds_re,
  input  logic [DW-1:0]               ds_wdata,
  output logic [DW-1:0]               ds_rdata,
  output logic [$clog2(IO_DEPTH)-1:0] io_addr,
  output logic                        io_we,
  output logic                        io_re,
  output logic [DW-1:0]               io_wdata,
  input  logic [DW-1:0]               io_rdata,
  input  logic                        ptr_en,
  input  logic [1:0]                  ptr_sel,
  input  logic                        ptr_dec,
  output logic [2*DW-1:0]             ptr_addr,
  output logic [2*DW-1:0]             x_ptr,
  output logic [2*DW-1:0]             y_ptr,
  output logic [2*DW-1:0]             z_ptr
);
  localparam int RW       = $clog2(NREG);
  localparam int SW       = $clog2(SRAM_DEPTH);
  localparam int PW       = 2 * DW;
  localparam int NPTR     = 3;
  localparam int PTR_BASE = NREG - 2 * NPTR;

  region_e       region;
  logic [RW-1:0] ds_reg_idx;
  logic [SW-1:0] sram_off;
  logic [DW-1:0] reg_rdata;
  logic [DW-1:0] sram [SRAM_DEPTH];
  logic [PW-1:0] ptr_val [NPTR];
  logic [PW-1:0] ptr_cur, ptr_nxt, ptr_ea;
  logic          ptr_go;
  logic [RW-1:0] ptr_lo_idx;

  gpr_addr_decode #(
    .AW(AW), .NREG(NREG), .IO_BASE(IO_BASE), .IO_DEPTH(IO_DEPTH),
    .SRAM_BASE(SRAM_BASE), .SRAM_DEPTH(SRAM_DEPTH)
  ) u_dec (
    .addr(ds_addr), .region(region), .reg_idx(ds_reg_idx),
    .io_off(io_addr), .sram_off(sram_off)
  );

  // pointer selection and step
  assign ptr_go     = ptr_en && (ptr_sel != PS_NONE);
  assign ptr_lo_idx = RW'(PTR_BASE) + RW'({ptr_sel, 1'b0});

  always_comb begin
    case (ptr_sel)
      PS_X:    ptr_cur = ptr_val[0];
      PS_Y:    ptr_cur = ptr_val[1];
      PS_Z:    ptr_cur = ptr_val[2];
      default: ptr_cur = '0;
    endcase
  end

  gpr_ptr_step #(.PW(PW)) u_step (
    .cur(ptr_cur), .dec(ptr_dec), .nxt(ptr_nxt), .eaddr(ptr_ea)
  );

  assign ptr_addr = ptr_go ? ptr_ea : '0;

  gpr_array #(.DW(DW), .NREG(NREG), .NPTR(NPTR)) u_arr (
    .clk(clk), .rst_n(rst_n),
    .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data),
    .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data),
    .rd_c_sel(ds_reg_idx), .rd_c_data(reg_rdata),
    .alu_we(alu_we), .alu_sel(alu_wsel), .alu_data(alu_wdata),
    .ptr_we(ptr_go), .ptr_lo_idx(ptr_lo_idx), .ptr_data(ptr_nxt),
    .ds_we(ds_we && region == RG_REG), .ds_sel(ds_reg_idx), .ds_data(ds_wdata),
    .ptr_val(ptr_val)
  );

  assign x_ptr = ptr_val[0];
  assign y_ptr = ptr_val[1];
  assign z_ptr = ptr_val[2];

  // internal SRAM
  always_ff @(posedge clk) begin
    if (ds_we && region == RG_SRAM)
      sram[sram_off] <= ds_wdata;
  end

  // I/O window
  assign io_we    = ds_we && region == RG_IO;
  assign io_re    = ds_re && region == RG_IO;
  assign io_wdata = ds_wdata;

  always_comb begin
    case (region)
      RG_REG:  ds_rdata = reg_rdata;
      RG_IO:   ds_rdata = io_rdata;
      RG_SRAM: ds_rdata = sram[sram_off];
      default: ds_rdata = '0;
    endcase
  end

  // R4: I/O strobes only for addresses inside the window
  p_io_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_we || io_re) |-> (int'(ds_addr) >= IO_BASE && int'(ds_addr) < IO_BASE + IO_DEPTH));

  // R6: the unmapped tail is silent
  p_unmapped_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(ds_addr) >= SRAM_BASE + SRAM_DEPTH) |-> (ds_rdata == '0 && !io_we && !io_re));

  // R9: an uncontested step moves the chosen pointer by exactly one
  p_ptr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_go && !alu_we) |=>
      ptr_val[$past(ptr_sel)] == ($past(ptr_dec) ? $past(ptr_cur) - PW'(1)
                                                 : $past(ptr_cur) + PW'(1)));
endmodule

// File: tb/gpr_file_test.sv
module gpr_file_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  rd_a_sel = '0, rd_b_sel = '0, alu_wsel = '0;
  logic [7:0]  rd_a_data, rd_b_data, alu_wdata = '0;
  logic        alu_we = 1'b0;
  logic [7:0]  ds_addr = 8'hF0, ds_wdata = '0, ds_rdata;
  logic        ds_we = 1'b0, ds_re = 1'b0;
  logic [5:0]  io_addr;
  logic        io_we, io_re;
  logic [7:0]  io_wdata, io_rdata = '0;
  logic        ptr_en = 1'b0, ptr_dec = 1'b0;
  logic [1:0]  ptr_sel = 2'd3;
  logic [15:0] ptr_addr, x_ptr, y_ptr, z_ptr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  gpr_file uut (
    .clk(clk), .rst_n(rst_n),
    .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data),
    .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data),
    .alu_we(alu_we), .alu_wsel(alu_wsel), .alu_wdata(alu_wdata),
    .ds_addr(ds_addr), .ds_we(ds_we), .ds_re(ds_re),
    .ds_wdata(ds_wdata), .ds_rdata(ds_rdata),
    .io_addr(io_addr), .io_we(io_we), .io_re(io_re),
    .io_wdata(io_wdata), .io_rdata(io_rdata),
    .ptr_en(ptr_en), .ptr_sel(ptr_sel), .ptr_dec(ptr_dec),
    .ptr_addr(ptr_addr), .x_ptr(x_ptr), .y_ptr(y_ptr), .z_ptr(z_ptr)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    alu_we = 0; ds_we = 0; ds_re = 0; ptr_en = 0; ptr_sel = 2'd3;
  endtask

  task automatic alu_wr(input logic [4:0] r, input logic [7:0] d);
    alu_we = 1; alu_wsel = r; alu_wdata = d;
    tick();
    alu_we = 0;
  endtask

  task automatic ds_wr(input logic [7:0] a, input logic [7:0] d);
    ds_addr = a; ds_wdata = d; ds_we = 1;
    tick();
    ds_we = 0;
  endtask

  task automatic ds_rd(input logic [7:0] a, input string tag, input logic [7:0] exp);
    ds_addr = a; #1;
    chk(tag, {8'h0, ds_rdata}, {8'h0, exp});
  endtask

  task automatic t_reset();
    ds_addr = 8'hF0; #1;
    chk("R4 reset io_we", {15'h0, io_we}, 16'h0);
    chk("R4 reset io_re", {15'h0, io_re}, 16'h0);
    chk("R6 reset unmapped read", {8'h0, ds_rdata}, 16'h0);
  endtask

  task automatic t_alu();
    alu_wr(5'd5, 8'h3C);
    alu_we = 1; alu_wsel = 5'd5; alu_wdata = 8'hC3; rd_a_sel = 5'd5; rd_b_sel = 5'd5; #1;
    chk("R2 old value during write", {8'h0, rd_a_data}, 16'h003C);
    tick(); alu_we = 0; #1;
    chk("R1 port A after write", {8'h0, rd_a_data}, 16'h00C3);
    chk("R1 port B after write", {8'h0, rd_b_data}, 16'h00C3);
    alu_wr(5'd0, 8'h01);
    alu_wr(5'd31, 8'hF1);
    rd_a_sel = 5'd0; rd_b_sel = 5'd31; #1;
    chk("R1 register 0", {8'h0, rd_a_data}, 16'h0001);
    chk("R1 register 31", {8'h0, rd_b_data}, 16'h00F1);
  endtask

  task automatic t_alias();
    ds_wr(8'h1F, 8'h77);
    rd_a_sel = 5'd31; #1;
    chk("R3 data write seen on ALU port", {8'h0, rd_a_data}, 16'h0077);
    alu_wr(5'd2, 8'h12);
    ds_rd(8'h02, "R3 ALU write seen on data port", 8'h12);
  endtask

  task automatic t_io();
    ds_addr = 8'h20; ds_wdata = 8'h55; ds_we = 1; #1;
    chk("R4 io_addr low edge", {10'h0, io_addr}, 16'h0000);
    chk("R4 io_we", {15'h0, io_we}, 16'h0001);
    chk("R4 io_wdata", {8'h0, io_wdata}, 16'h0055);
    tick(); ds_we = 0;
    ds_addr = 8'h5F; ds_re = 1; io_rdata = 8'h9A; #1;
    chk("R4 io_addr high edge", {10'h0, io_addr}, 16'h003F);
    chk("R4 io_re", {15'h0, io_re}, 16'h0001);
    chk("R4 io read data", {8'h0, ds_rdata}, 16'h009A);
    ds_addr = 8'h1F; ds_we = 1; ds_wdata = 8'h77; #1;
    chk("R4 no io_we below window", {15'h0, io_we}, 16'h0000);
    ds_we = 0; ds_addr = 8'h60; #1;
    chk("R4 no io_re above window", {15'h0, io_re}, 16'h0000);
    ds_re = 0;
  endtask

  task automatic t_sram();
    ds_wr(8'h60, 8'h11);
    ds_wr(8'hDF, 8'h22);
    ds_wr(8'h65, 8'h33);
    ds_rd(8'h60, "R5 sram first byte", 8'h11);
    ds_rd(8'hDF, "R5 sram last byte", 8'h22);
    ds_rd(8'h65, "R5 sram middle byte", 8'h33);
  endtask

  task automatic t_unmapped();
    ds_wr(8'hE5, 8'hEE);
    ds_rd(8'hE5, "R6 unmapped reads zero", 8'h00);
    ds_rd(8'h65, "R6 sram untouched", 8'h33);
    rd_a_sel = 5'd5; #1;
    chk("R6 register untouched", {8'h0, rd_a_data}, 16'h00C3);
  endtask

  task automatic t_conflict();
    alu_we = 1; alu_wsel = 5'd9; alu_wdata = 8'hAA;
    ds_we = 1; ds_addr = 8'h09; ds_wdata = 8'h55;
    tick(); idle();
    rd_a_sel = 5'd9; #1;
    chk("R7 ALU wins collision", {8'h0, rd_a_data}, 16'h00AA);
  endtask

  task automatic t_ptr();
    alu_wr(5'd26, 8'hFF); alu_wr(5'd27, 8'hFF);
    alu_wr(5'd28, 8'h34); alu_wr(5'd29, 8'h12);
    alu_wr(5'd30, 8'h00); alu_wr(5'd31, 8'h01);
    #1;
    chk("R8 X pair", x_ptr, 16'hFFFF);
    chk("R8 Y pair", y_ptr, 16'h1234);
    chk("R8 Z pair", z_ptr, 16'h0100);
    ptr_en = 1; ptr_sel = 2'd0; ptr_dec = 0; #1;
    chk("R9 X post-inc address", ptr_addr, 16'hFFFF);
    tick(); idle(); #1;
    chk("R9 X wraps up", x_ptr, 16'h0000);
    ptr_en = 1; ptr_sel = 2'd0; ptr_dec = 1; #1;
    chk("R9 X pre-dec address", ptr_addr, 16'hFFFF);
    tick(); idle(); #1;
    chk("R9 X wraps down", x_ptr, 16'hFFFF);
    ptr_en = 1; ptr_sel = 2'd1; ptr_dec = 1; #1;
    chk("R9 Y pre-dec address", ptr_addr, 16'h1233);
    tick(); idle(); #1;
    chk("R9 Y decremented", y_ptr, 16'h1233);
    ptr_en = 1; ptr_sel = 2'd2; ptr_dec = 0; #1;
    chk("R9 Z post-inc address", ptr_addr, 16'h0100);
    tick(); idle(); #1;
    chk("R9 Z incremented", z_ptr, 16'h0101);
    ptr_en = 1; ptr_sel = 2'd3; ptr_dec = 0;
    tick(); idle(); #1;
    chk("R9 select 3 leaves X", x_ptr, 16'hFFFF);
    chk("R9 select 3 leaves Y", y_ptr, 16'h1233);
    chk("R9 select 3 leaves Z", z_ptr, 16'h0101);
  endtask

  task automatic t_prio();
    ptr_en = 1; ptr_sel = 2'd2; ptr_dec = 0;
    alu_we = 1; alu_wsel = 5'd31; alu_wdata = 8'h80;
    tick(); idle(); #1;
    chk("R10 ALU byte beats step", z_ptr, 16'h8002);
    ptr_en = 1; ptr_sel = 2'd1; ptr_dec = 1;
    ds_we = 1; ds_addr = 8'h1C; ds_wdata = 8'h99;
    tick(); idle(); #1;
    chk("R10 step beats data write", y_ptr, 16'h1232);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_alu();
    t_alias();
    t_io();
    t_sram();
    t_unmapped();
    t_conflict();
    t_ptr();
    t_prio();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule